// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block lets an external host read and write a small bank of byte-wide housekeeping and configuration registers over a four-wire serial link in clock mode 0. The host pulls chip select low, clocks in a command byte, then an address byte, then any number of data bytes. After each data byte the register address steps up by one, so a whole run of registers can be read or written in a single chip-select frame. One writable register drives an external reset line for logic outside this block.

The serial pins are sampled with the local system clock through synchronizer stages, and edges of the serial clock are found in that domain. This keeps the whole block in one clock domain. The system clock must run at least several times faster than the serial clock. A state machine walks through the phases of a frame. From ST_IDLE (chip select high) it enters ST_CMD when chip select goes low. ST_CMD moves to ST_RADDR on a read command, to ST_WADDR on a write command, and to ST_SKIP on any other code. ST_RADDR moves to ST_RDATA and ST_WADDR moves to ST_WDATA once the address byte is complete. ST_RDATA, ST_WDATA and ST_SKIP hold until chip select rises. A high chip select sends any state back to ST_IDLE.

Top module: `spi_cfg_slave`

## Requirements
- R1: Bits move most-significant first, eight per byte. The slave takes spi_mosi on each rising edge of spi_sck and changes spi_miso only after falling edges, so a read bit is steady while spi_sck is low before the rising edge where the host takes it. The first read bit is ready after the fall that follows the last address bit.
- R2: When spi_cs_n goes high, any partial byte is dropped and the slave returns to waiting for a command byte. The next frame is decoded from its first bit.
- R3: A first byte of 0x40 starts a streaming read and 0x80 starts a streaming write. In both cases the second byte is the register address.
- R4: The address goes up by one after every data byte, in reads and in writes alike. It wraps from 0xFF to 0x00.
- R5: After reset, addresses 0 to 18 read as 0x00, 0x04, 0x56, 0x11, 0x00, 0x00, 0x00, 0x00, 0x02, 0x01, 0x00, 0x00, 0x00, 0xFF, 0xEF, 0xFF, 0x03, 0x12, 0x04, in that address order.
- R6: Addresses 0 to 3 are read-only. Address 3 is the product identifier 0x11, and addresses 1 and 2 are further fixed identification bytes. Writes to addresses 0 to 3 change nothing. Addresses 4 to 18 accept all eight bits.
- R7: Bit 0 of register 0x0B drives ext_rst_o, active high. Writing 0x01 there asserts it and writing 0x00 releases it. ext_rst_o does not reset this block.
- R8: Any first byte other than 0x40 or 0x80 makes the rest of the frame ignored until spi_cs_n rises. No register changes, spi_miso stays 0 and spi_miso_oe stays 0.
- R9: Writes to addresses 19 and above are discarded. Reads from those addresses return 0x00.
- R10: spi_miso_oe is 1 only while spi_cs_n is low and a read is in its data phase. Whenever spi_miso_oe is 0, spi_miso is 0.
- R11: Driving rst_n low asynchronously restores every register to its R5 value and clears ext_rst_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low frame select from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial read data to the host |
| spi_miso_oe | output | 1 | Output enable for spi_miso |
| ext_rst_o | output | 1 | External reset request, active high |

## Verification
The bench builds the block with its default parameters: 19 registers, 4 read-only entries, the reset-control register at 0x0B and two synchronizer stages. It drives the serial clock at one eighteenth of the system clock per half bit. These settings put every mapped address within reach of one streaming frame, along with the unmapped addresses just past the bank and the edge between read-only and writable entries. With two synchronizer stages, the fall-to-output path stays well inside the low phase the bench gives the host, so each read bit can be compared at the point where a host would take it.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] CMD_STREAM_RD = 8'h40;
    localparam logic [BYTE_W-1:0] CMD_STREAM_WR = 8'h80;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_RADDR,
        ST_WADDR,
        ST_RDATA,
        ST_WDATA,
        ST_SKIP
    } link_state_t;

    // Power-on contents of the register bank, by address.
    function automatic logic [BYTE_W-1:0] default_val(input int idx);
        logic [BYTE_W-1:0] v;
        case (idx)
            1:       v = 8'h04;
            2:       v = 8'h56;
            3:       v = 8'h11;
            8:       v = 8'h02;
            9:       v = 8'h01;
            13:      v = 8'hFF;
            14:      v = 8'hEF;
            15:      v = 8'hFF;
            16:      v = 8'h03;
            17:      v = 8'h12;
            18:      v = 8'h04;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_in,
    input  logic cs_n_in,
    input  logic mosi_in,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_act,
    output logic mosi_s
);

    localparam int TOP = STAGES - 1;

    logic [TOP:0] sck_p;
    logic [TOP:0] cs_p;
    logic [TOP:0] mosi_p;
    logic         sck_d;

    // STAGES must be 2 or more.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_p  <= '0;
            cs_p   <= '1;
            mosi_p <= '0;
            sck_d  <= 1'b0;
        end else begin
            sck_p  <= {sck_p[TOP-1:0], sck_in};
            cs_p   <= {cs_p[TOP-1:0], cs_n_in};
            mosi_p <= {mosi_p[TOP-1:0], mosi_in};
            sck_d  <= sck_p[TOP];
        end
    end

    assign sck_rise = sck_p[TOP] & ~sck_d;
    assign sck_fall = ~sck_p[TOP] & sck_d;
    assign cs_act   = ~cs_p[TOP];
    assign mosi_s   = mosi_p[TOP];

endmodule

// File: rtl/spi_cfg_fsm.sv
module spi_cfg_fsm
    import spi_cfg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_act,
    input  logic                 sck_rise,
    input  logic                 sck_fall,
    input  logic                 mosi_bit,
    input  logic [BYTE_W-1:0]    rd_byte,
    output link_state_t          state,
    output logic [2:0]           bit_cnt,
    output logic [ADDR_W-1:0]    addr,
    output logic                 wr_en,
    output logic [BYTE_W-1:0]    wr_data,
    output logic                 miso,
    output logic                 miso_oe
);

    link_state_t       state_nxt;
    logic [BYTE_W-1:0] rx_sr;
    logic [BYTE_W-1:0] rx_nxt;
    logic [BYTE_W-1:0] tx_sr;
    logic              load_pend;
    logic              byte_end;

    assign rx_nxt   = {rx_sr[BYTE_W-2:0], mosi_bit};
    assign byte_end = sck_rise && (bit_cnt == 3'd7) && (state != ST_IDLE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Next-state decode
    always_comb begin
        state_nxt = state;
        if (!cs_act) begin
            state_nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  state_nxt = ST_CMD;
                ST_CMD: begin
                    if (byte_end) begin
                        if (rx_nxt == CMD_STREAM_RD) begin
                            state_nxt = ST_RADDR;
                        end else if (rx_nxt == CMD_STREAM_WR) begin
                            state_nxt = ST_WADDR;
                        end else begin
                            state_nxt = ST_SKIP;
                        end
                    end
                end
                ST_RADDR: if (byte_end) state_nxt = ST_RDATA;
                ST_WADDR: if (byte_end) state_nxt = ST_WDATA;
                ST_RDATA: state_nxt = ST_RDATA;
                ST_WDATA: state_nxt = ST_WDATA;
                ST_SKIP:  state_nxt = ST_SKIP;
                default:  state_nxt = ST_IDLE;
            endcase
        end
    end

    // Shift, count and address datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sr     <= '0;
            tx_sr     <= '0;
            bit_cnt   <= '0;
            addr      <= '0;
            load_pend <= 1'b0;
        end else if (!cs_act) begin
            rx_sr     <= '0;
            tx_sr     <= '0;
            bit_cnt   <= '0;
            load_pend <= 1'b0;
        end else begin
            if (sck_rise && state != ST_IDLE) begin
                rx_sr   <= rx_nxt;
                bit_cnt <= bit_cnt + 3'd1;
            end
            if (byte_end && (state == ST_RADDR || state == ST_WADDR)) begin
                addr <= ADDR_W'(rx_nxt);
            end
            if (byte_end && (state == ST_RDATA || state == ST_WDATA)) begin
                addr <= addr + ADDR_W'(1);
            end
            if (byte_end && (state == ST_RADDR || state == ST_RDATA)) begin
                load_pend <= 1'b1;
            end
            if (sck_fall && state == ST_RDATA) begin
                if (load_pend) begin
                    tx_sr     <= rd_byte;
                    load_pend <= 1'b0;
                end else begin
                    tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

    // Outputs
    always_comb begin
        wr_en   = (state == ST_WDATA) && byte_end;
        wr_data = rx_nxt;
        miso_oe = (state == ST_RDATA) && cs_act;
        miso    = miso_oe ? tx_sr[BYTE_W-1] : 1'b0;
    end

endmodule

// File: rtl/spi_cfg_regfile.sv
module spi_cfg_regfile
    import spi_cfg_pkg::*;
#(
    parameter int NREGS  = 19,
    parameter int RO_CNT = 4,
    parameter int ADDR_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [BYTE_W-1:0]         wr_data,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [BYTE_W-1:0]         rd_data,
    output logic [NREGS*BYTE_W-1:0]   q_flat
);

    logic [BYTE_W-1:0] q_all [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        if (g < RO_CNT) begin : g_ro
            assign q_all[g] = default_val(g);
        end else begin : g_rw
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q_all[g] <= default_val(g);
                end else if (wr_en && wr_addr == ADDR_W'(g)) begin
                    q_all[g] <= wr_data;
                end
            end
        end
        assign q_flat[g*BYTE_W +: BYTE_W] = q_all[g];
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NREGS; k++) begin
            if (rd_addr == ADDR_W'(k)) begin
                rd_data = q_all[k];
            end
        end
    end

endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
    import spi_cfg_pkg::*;
#(
    parameter int NREGS       = 19,
    parameter int RO_CNT      = 4,
    parameter int EXT_ADDR    = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso,
    output logic spi_miso_oe,
    output logic ext_rst_o
);

    localparam int ADDR_W = BYTE_W;
    localparam int FLAT_W = NREGS * BYTE_W;

    logic              sck_rise;
    logic              sck_fall;
    logic              cs_act;
    logic              mosi_s;
    link_state_t       state;
    logic [2:0]        bit_cnt;
    logic [ADDR_W-1:0] addr;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_data;
    logic [BYTE_W-1:0] rd_data;
    logic [FLAT_W-1:0] q_flat;

    spi_cfg_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_in   (spi_sck),
        .cs_n_in  (spi_cs_n),
        .mosi_in  (spi_mosi),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_act   (cs_act),
        .mosi_s   (mosi_s)
    );

    spi_cfg_fsm #(
        .ADDR_W (ADDR_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_act   (cs_act),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .mosi_bit (mosi_s),
        .rd_byte  (rd_data),
        .state    (state),
        .bit_cnt  (bit_cnt),
        .addr     (addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .miso     (spi_miso),
        .miso_oe  (spi_miso_oe)
    );

    spi_cfg_regfile #(
        .NREGS  (NREGS),
        .RO_CNT (RO_CNT),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (addr),
        .wr_data (wr_data),
        .rd_addr (addr),
        .rd_data (rd_data),
        .q_flat  (q_flat)
    );

    assign ext_rst_o = q_flat[EXT_ADDR*BYTE_W];

endmodule

// File: rtl/spi_cfg_chk.sv
module spi_cfg_chk
    import spi_cfg_pkg::*;
#(
    parameter int NREGS    = 19,
    parameter int RO_CNT   = 4,
    parameter int EXT_ADDR = 11,
    parameter int ADDR_W   = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cs_act,
    input logic                     sck_rise,
    input logic [2:0]               bit_cnt,
    input link_state_t              state,
    input logic [ADDR_W-1:0]        addr,
    input logic                     wr_en,
    input logic [NREGS*BYTE_W-1:0]  q_flat,
    input logic                     ext_rst_o,
    input logic                     spi_miso,
    input logic                     spi_miso_oe
);

    // R10
    oe_needs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_miso_oe |-> (cs_act && state == ST_RDATA));

    // R10
    miso_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_miso_oe |-> !spi_miso);

    // R2
    cs_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (state == ST_IDLE && bit_cnt == 3'd0));

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && sck_rise && bit_cnt == 3'd7 &&
         (state == ST_RDATA || state == ST_WDATA))
        |=> (addr == $past(addr) + ADDR_W'(1)));

    // R7
    ext_rst_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ext_rst_o) |-> $past(wr_en && addr == ADDR_W'(EXT_ADDR)));

    // R6
    ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr < ADDR_W'(RO_CNT)) |=> $stable(q_flat));

    // R9
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr >= ADDR_W'(NREGS)) |=> $stable(q_flat));

    // R8
    skip_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> (!wr_en && !spi_miso_oe));

endmodule

bind spi_cfg_slave spi_cfg_chk #(
    .NREGS    (NREGS),
    .RO_CNT   (RO_CNT),
    .EXT_ADDR (EXT_ADDR),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_act      (cs_act),
    .sck_rise    (sck_rise),
    .bit_cnt     (bit_cnt),
    .state       (state),
    .addr        (addr),
    .wr_en       (wr_en),
    .q_flat      (q_flat),
    .ext_rst_o   (ext_rst_o),
    .spi_miso    (spi_miso),
    .spi_miso_oe (spi_miso_oe)
);

// File: tb/spi_cfg_slave_bench.sv
module spi_cfg_slave_bench;

    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n;
    logic sck;
    logic cs_n;
    logic mosi;
    logic miso;
    logic miso_oe;
    logic ext_rst;

    int total = 0;
    int bad   = 0;

    logic [7:0] mdl [256];

    always #2 clk = ~clk;

    spi_cfg_slave #(
        .NREGS       (19),
        .RO_CNT      (4),
        .EXT_ADDR    (11),
        .SYNC_STAGES (2)
    ) u_spi_cfg_slave (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_sck     (sck),
        .spi_cs_n    (cs_n),
        .spi_mosi    (mosi),
        .spi_miso    (miso),
        .spi_miso_oe (miso_oe),
        .ext_rst_o   (ext_rst)
    );

    function automatic logic [7:0] dflt(input int a);
        case (a)
            1: return 8'h04;   2: return 8'h56;   3: return 8'h11;
            8: return 8'h02;   9: return 8'h01;   13: return 8'hFF;
            14: return 8'hEF;  15: return 8'hFF;  16: return 8'h03;
            17: return 8'h12;  18: return 8'h04;
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_reset();
        for (int a = 0; a < 256; a++) mdl[a] = dflt(a);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Shift n bits MSB-first; report the bits seen and the output enable.
    task automatic xfer(input logic [7:0] o, input int n, output logic [7:0] i,
                        output logic oe_all, output logic oe_any, output logic miso_any);
        i = '0; oe_all = 1'b1; oe_any = 1'b0; miso_any = 1'b0;
        for (int b = 7; b > 7 - n; b--) begin
            wait_clk(HALF);
            mosi = o[b];
            wait_clk(HALF);
            i[b]     = miso;
            oe_all   = oe_all & miso_oe;
            oe_any   = oe_any | miso_oe;
            miso_any = miso_any | miso;
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic cs_open();
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic cs_close();
        wait_clk(HALF);
        cs_n = 1'b1;
        mosi = 1'b0;
        wait_clk(HALF + 4);
    endtask

    task automatic idle_chk(input string req);
        chk({req, " idle oe"}, miso_oe, 1'b0);
        chk({req, " idle miso"}, miso, 1'b0);
        chk({req, " ext_rst"}, ext_rst, mdl[11][0]);
    endtask

    task automatic rd_stream(input string req, input logic [7:0] a, input int n);
        logic [7:0] got; logic oa, oy, my;
        logic hdr_oe;
        cs_open();
        xfer(8'h40, 8, got, oa, oy, my);
        hdr_oe = oy;
        xfer(a, 8, got, oa, oy, my);
        hdr_oe = hdr_oe | oy;
        chk({req, " R10 oe low in header"}, hdr_oe, 1'b0);
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, 8, got, oa, oy, my);
            chk($sformatf("%s R1 R4 byte at 0x%02h", req, 8'(a + k)), got, mdl[8'(a + k)]);
            chk({req, " R10 oe high in data"}, oa, 1'b1);
        end
        cs_close();
        idle_chk(req);
    endtask

    task automatic wr_stream(input string req, input logic [7:0] a, input logic [7:0] d [$]);
        logic [7:0] got; logic oa, oy, my;
        cs_open();
        xfer(8'h80, 8, got, oa, oy, my);
        xfer(a, 8, got, oa, oy, my);
        foreach (d[k]) begin
            logic [7:0] wa;
            xfer(d[k], 8, got, oa, oy, my);
            chk({req, " R10 no oe in write"}, oy, 1'b0);
            wa = 8'(a + k);
            if (wa >= 8'd4 && wa < 8'd19) mdl[wa] = d[k];
        end
        cs_close();
        idle_chk(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] got; logic oa, oy, my;
        rst_n = 1'b0; sck = 1'b0; cs_n = 1'b1; mosi = 1'b0;
        model_reset();
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // R11 reset state at the ports
        chk("R11 ext_rst after reset", ext_rst, 1'b0);
        chk("R10 oe after reset", miso_oe, 1'b0);

        // R5 R3 R6 whole bank in one streaming read
        rd_stream("R5", 8'h00, 19);
        // R9 reading past the bank
        rd_stream("R9", 8'h11, 4);

        // R7 assert and release external reset
        wr_stream("R7 set", 8'h0B, '{8'h01});
        chk("R7 ext_rst asserted", ext_rst, 1'b1);
        // R7 block still works while ext_rst is high
        wr_stream("R7 busy", 8'h0D, '{8'hA5, 8'h5A, 8'h3C});
        rd_stream("R7 busy", 8'h0C, 5);
        wr_stream("R7 clr", 8'h0B, '{8'h00});
        chk("R7 ext_rst released", ext_rst, 1'b0);

        // R6 writes across the read-only edge
        wr_stream("R6", 8'h01, '{8'hAA, 8'hBB, 8'hCC, 8'hDD});
        rd_stream("R6", 8'h00, 6);

        // R9 writes past the bank are dropped, incl. wrap at 0xFF (R4)
        wr_stream("R9", 8'h12, '{8'h99, 8'h98, 8'h97});
        rd_stream("R9", 8'h12, 3);
        wr_stream("R4 wrap", 8'hFF, '{8'h55, 8'h66});
        rd_stream("R4 wrap", 8'hFE, 4);

        // R8 unknown command: no write, no drive
        cs_open();
        xfer(8'hC3, 8, got, oa, oy, my);
        xfer(8'h0E, 8, got, oa, oy, my);
        xfer(8'h77, 8, got, oa, oy, my);
        chk("R8 oe stays low", oy, 1'b0);
        chk("R8 miso stays low", my, 1'b0);
        xfer(8'h00, 8, got, oa, oy, my);
        chk("R8 miso low in read slot", my, 1'b0);
        cs_close();
        rd_stream("R8", 8'h0E, 1);

        // R2 partial command byte, then a fresh frame
        cs_open();
        xfer(8'h80, 4, got, oa, oy, my);
        cs_close();
        rd_stream("R2 after partial cmd", 8'h0F, 2);
        // R2 partial data byte is dropped
        cs_open();
        xfer(8'h80, 8, got, oa, oy, my);
        xfer(8'h0F, 8, got, oa, oy, my);
        xfer(8'h12, 5, got, oa, oy, my);
        cs_close();
        rd_stream("R2 after partial data", 8'h0F, 1);

        // R11 asynchronous reset restores defaults
        wr_stream("R11 prep", 8'h0B, '{8'h01, 8'h44});
        chk("R11 ext_rst before reset", ext_rst, 1'b1);
        wait_clk(3);
        #1 rst_n = 1'b0;
        #1;
        chk("R11 ext_rst cleared asynchronously", ext_rst, 1'b0);
        wait_clk(3);
        rst_n = 1'b1;
        model_reset();
        wait_clk(4);
        rd_stream("R11", 8'h00, 19);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule